// File: doc/BRIEF.md
# NAND Page Read and Bad-Block Controller

This block walks an 8-bit NAND device through page reads. It has two modes. In page mode it reads one page. In block mode it reads a whole erase block. For each page it issues a read command, the column and row address bytes, and a confirm command to a downstream command/address sequencer. It then waits for the device ready line and fetches bytes one at a time over a read strobe handshake. The 2048 data bytes of the page leave the block as a valid/ready byte stream that carries each byte's index within the page. The 64 spare bytes that follow in the same burst are not streamed. The block keeps only the per-chunk ECC code bytes and the bad-block marker from them.

When the spare area has been read, the block asks an external corrector to check each 512-byte chunk, one request at a time, in chunk order. Each request carries the 3-byte code stored for that chunk. If any chunk comes back uncorrectable, the whole operation stops with an ECC-failure status.

Block mode first reads the spare area of the block's first page. If the marker byte is not 0xFF, the block is reported bad and no page is read. Otherwise the block reads the consecutive pages of the erase block in turn.

The output stream follows valid/ready rules. `out_valid` rises with a byte and stays high, with `out_data` and `out_index` unchanged, until a cycle in which `out_ready` is high. No further device byte is fetched while a byte is waiting. The sequencer port follows the same rule for `seq_byte` and `seq_is_cmd`, and the check port follows it for `chk_chunk` and `chk_code`.

Top module: `nand_page_reader`

## Requirements
- R1: Each page access sends six bytes to the sequencer in this order: command 0x00, column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, command 0x30. `seq_is_cmd` is 1 only on the two command bytes. The byte is held stable while `seq_ready` is low.
- R2: No read strobe (`rd_req`) is raised after a confirm command until `dev_ready` has been seen high.
- R3: A page read fetches 2112 bytes. The first 2048 bytes go out on the stream with `out_index` counting 0 to 2047 in order. The 64 spare bytes are fetched but not streamed.
- R4: The code of chunk c (c = 0..3) is built from spare offsets 3c+1, 3c+2 and 3c+3. Offset 3c+1 goes to `chk_code[7:0]` and offset 3c+3 goes to `chk_code[23:16]`.
- R5: After the spare bytes, checks are requested for chunks 0, 1, 2 and 3 in that order. The next request is not issued until `res_valid` has returned for the previous one.
- R6: A result with `res_uncorr`=1 ends the operation at once with status 2 (ECC failure). No further check is requested and no further page is read.
- R7: Block mode first reads the 64 spare bytes of the base row at column 2048. If spare byte 0 is not 0xFF, the operation ends with status 1 (bad block) and no page data is read. Page mode never checks the marker.
- R8: In block mode with a good marker, PAGES_PER_BLOCK pages are read from rows base, base+1, and so on, each in full. The operation ends with status 0 (success) if all chunks pass.
- R9: `ce_n` goes low when a page access starts and returns high after the last spare byte is fetched. It is high whenever the block is idle and whenever a check is outstanding.
- R10: `busy` is high from the cycle after an accepted `start` until the operation ends. `done` then pulses for one cycle with `busy` low, and `status` holds its value until the next operation.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_index` stay stable and `rd_req` stays low.
- R12: After reset, `busy`, `done`, `seq_valid`, `rd_req`, `out_valid` and `chk_valid` are 0, `ce_n` is 1 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| block_mode | input | 1 | 1 = bad-block check then whole block, 0 = single page |
| base_row | input | ROW_W | Row (page) address of the page or of the block's first page |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | 0 success, 1 bad block, 2 ECC failure |
| ce_n | output | 1 | Device chip enable, active low |
| seq_valid | output | 1 | Command/address byte valid |
| seq_ready | input | 1 | Sequencer accepts byte |
| seq_is_cmd | output | 1 | 1 = command byte, 0 = address byte |
| seq_byte | output | 8 | Command or address byte |
| dev_ready | input | 1 | Device ready (not busy) |
| rd_req | output | 1 | Request one byte from the device |
| rd_ack | input | 1 | Byte returned on rd_data this cycle |
| rd_data | input | 8 | Device byte |
| out_valid | output | 1 | Page data byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Page data byte |
| out_index | output | IDX_W | Byte position within page |
| chk_valid | output | 1 | Chunk check request valid |
| chk_ready | input | 1 | Corrector accepts request |
| chk_chunk | output | CK_W | Chunk number |
| chk_code | output | 24 | Stored code of that chunk |
| res_valid | input | 1 | Check result valid |
| res_uncorr | input | 1 | Chunk uncorrectable |

## Verification
A wrong byte counter shows up on the stream at the first misplaced byte as a bad `out_index` or data value. It also shows up as the wrong number of strobes before the check phase. A wrong spare offset decode shows up in the first `chk_code` of that page, a few cycles after the last spare fetch. A wrong page or chunk counter shows up at the end of the operation: the row bytes seen on the sequencer are wrong, the number of check requests is wrong, or `status` is wrong. A chip-enable or ready-wait fault shows up in the same cycle as the strobe that breaks the rule.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;
  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] MARK_GOOD   = 8'hFF;

  localparam logic [1:0] ST_OK  = 2'd0;
  localparam logic [1:0] ST_BAD = 2'd1;
  localparam logic [1:0] ST_ECC = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_WAIT, S_READ, S_PUSH, S_MARK, S_CHECK, S_RESULT
  } rd_state_t;
endpackage

// File: rtl/nand_addr_emitter.sv
module nand_addr_emitter #(
  parameter int COL_W = 12,
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             seq_ready,
  output logic             seq_valid,
  output logic             seq_is_cmd,
  output logic [7:0]       seq_byte,
  output logic             finished
);
  import nand_rd_pkg::*;

  localparam int COL_BYTES = 2;
  localparam int ROW_BYTES = (ROW_W + 7) / 8;
  localparam int NSTEP     = 2 + COL_BYTES + ROW_BYTES;
  localparam int STEP_W    = $clog2(NSTEP);

  logic              active;
  logic [STEP_W-1:0] step;
  logic [COL_W-1:0]  col_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_BYTES*8-1:0] colp;
  logic [ROW_BYTES*8-1:0] rowp;

  always_comb begin
    colp = '0;
    colp[COL_W-1:0] = col_q;
    rowp = '0;
    rowp[ROW_W-1:0] = row_q;
  end

  always_comb begin
    int sel;
    sel        = int'(step);
    seq_is_cmd = 1'b0;
    seq_byte   = 8'h00;
    if (sel == 0) begin
      seq_is_cmd = 1'b1;
      seq_byte   = CMD_READ;
    end else if (sel == NSTEP - 1) begin
      seq_is_cmd = 1'b1;
      seq_byte   = CMD_CONFIRM;
    end else if (sel <= COL_BYTES) begin
      seq_byte = colp[8*(sel-1) +: 8];
    end else begin
      seq_byte = rowp[8*(sel-1-COL_BYTES) +: 8];
    end
  end

  assign seq_valid = active;
  assign finished  = active && seq_ready && (step == STEP_W'(NSTEP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (!active) begin
      if (launch) begin
        active <= 1'b1;
        step   <= '0;
        col_q  <= col;
        row_q  <= row;
      end
    end else if (seq_ready) begin
      if (finished) active <= 1'b0;
      else          step   <= step + 1'b1;
    end
  end

  assert_seq_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_valid && !seq_ready) |=> (seq_valid && $stable(seq_byte) && $stable(seq_is_cmd)));
endmodule

// File: rtl/nand_spare_capture.sv
module nand_spare_capture #(
  parameter int CHUNKS     = 4,
  parameter int CODE_BYTES = 3,
  parameter int OFF_W      = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [OFF_W-1:0]               off,
  input  logic [7:0]                     data,
  output logic [7:0]                     marker,
  output logic [CHUNKS*CODE_BYTES*8-1:0] codes
);
  localparam int NCODE = CHUNKS * CODE_BYTES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   marker <= 8'h00;
    else if (wr && off == '0)     marker <= data;
  end

  for (genvar k = 0; k < NCODE; k++) begin : g_code
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              codes[8*k +: 8] <= 8'h00;
      else if (wr && off == OFF_W'(k + 1))     codes[8*k +: 8] <= data;
    end
  end

  assert_first_code_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == OFF_W'(1)) |=> (codes[7:0] == $past(data)));
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int PAGE_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int CHUNKS          = 4,
  parameter int CODE_BYTES      = 3,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int ROW_W           = 16,
  localparam int IDX_W  = $clog2(PAGE_BYTES),
  localparam int CK_W   = $clog2(CHUNKS),
  localparam int CODE_W = CODE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              block_mode,
  input  logic [ROW_W-1:0]  base_row,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              ce_n,
  output logic              seq_valid,
  input  logic              seq_ready,
  output logic              seq_is_cmd,
  output logic [7:0]        seq_byte,
  input  logic              dev_ready,
  output logic              rd_req,
  input  logic              rd_ack,
  input  logic [7:0]        rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [IDX_W-1:0]  out_index,
  output logic              chk_valid,
  input  logic              chk_ready,
  output logic [CK_W-1:0]   chk_chunk,
  output logic [CODE_W-1:0] chk_code,
  input  logic              res_valid,
  input  logic              res_uncorr
);
  import nand_rd_pkg::*;

  localparam int COL_W  = $clog2(PAGE_BYTES) + 1;
  localparam int CNT_W  = $clog2(PAGE_BYTES + SPARE_BYTES) + 1;
  localparam int SOFF_W = $clog2(SPARE_BYTES);
  localparam int PG_W   = $clog2(PAGES_PER_BLOCK) + 1;
  localparam int LAST   = PAGE_BYTES + SPARE_BYTES - 1;

  rd_state_t        state;
  logic             blk, spare_only, launch_q, done_q;
  logic [1:0]       status_q;
  logic [ROW_W-1:0] row_cur;
  logic [PG_W-1:0]  pages_done;
  logic [CNT_W-1:0] cnt;
  logic [CK_W-1:0]  chunk;
  logic [7:0]       data_q, marker;
  logic             emit_done, spare_wr, in_spare;
  logic [SOFF_W-1:0] soff;
  logic [CHUNKS*CODE_W-1:0] codes;
  logic             ce_n_q;

  assign in_spare = (cnt >= CNT_W'(PAGE_BYTES));
  assign soff     = SOFF_W'(cnt - CNT_W'(PAGE_BYTES));
  assign spare_wr = (state == S_READ) && rd_ack && in_spare;

  nand_addr_emitter #(.COL_W(COL_W), .ROW_W(ROW_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_q),
    .col       (spare_only ? COL_W'(PAGE_BYTES) : COL_W'(0)),
    .row       (row_cur),
    .seq_ready (seq_ready),
    .seq_valid (seq_valid),
    .seq_is_cmd(seq_is_cmd),
    .seq_byte  (seq_byte),
    .finished  (emit_done)
  );

  nand_spare_capture #(.CHUNKS(CHUNKS), .CODE_BYTES(CODE_BYTES), .OFF_W(SOFF_W)) u_spare (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (spare_wr),
    .off   (soff),
    .data  (rd_data),
    .marker(marker),
    .codes (codes)
  );

  assign busy      = (state != S_IDLE);
  assign done      = done_q;
  assign status    = status_q;
  assign ce_n      = ce_n_q;
  assign rd_req    = (state == S_READ);
  assign out_valid = (state == S_PUSH);
  assign out_data  = data_q;
  assign out_index = cnt[IDX_W-1:0];
  assign chk_valid = (state == S_CHECK);
  assign chk_chunk = chunk;
  assign chk_code  = codes[CODE_W*chunk +: CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      blk        <= 1'b0;
      spare_only <= 1'b0;
      launch_q   <= 1'b0;
      done_q     <= 1'b0;
      status_q   <= ST_OK;
      row_cur    <= '0;
      pages_done <= '0;
      cnt        <= '0;
      chunk      <= '0;
      data_q     <= 8'h00;
      ce_n_q     <= 1'b1;
    end else begin
      launch_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          blk        <= block_mode;
          spare_only <= block_mode;
          row_cur    <= base_row;
          pages_done <= '0;
          launch_q   <= 1'b1;
          ce_n_q     <= 1'b0;
          state      <= S_CMD;
        end
        S_CMD: if (emit_done) state <= S_WAIT;
        S_WAIT: if (dev_ready) begin
          cnt   <= spare_only ? CNT_W'(PAGE_BYTES) : '0;
          state <= S_READ;
        end
        S_READ: if (rd_ack) begin
          if (!in_spare) begin
            data_q <= rd_data;
            state  <= S_PUSH;
          end else if (cnt == CNT_W'(LAST)) begin
            ce_n_q <= 1'b1;
            chunk  <= '0;
            state  <= spare_only ? S_MARK : S_CHECK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PUSH: if (out_ready) begin
          cnt   <= cnt + 1'b1;
          state <= S_READ;
        end
        S_MARK: if (marker != MARK_GOOD) begin
          status_q <= ST_BAD;
          done_q   <= 1'b1;
          state    <= S_IDLE;
        end else begin
          spare_only <= 1'b0;
          launch_q   <= 1'b1;
          ce_n_q     <= 1'b0;
          state      <= S_CMD;
        end
        S_CHECK: if (chk_ready) state <= S_RESULT;
        S_RESULT: if (res_valid) begin
          if (res_uncorr) begin
            status_q <= ST_ECC;
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end else if (chunk != CK_W'(CHUNKS - 1)) begin
            chunk <= chunk + 1'b1;
            state <= S_CHECK;
          end else if (blk && pages_done != PG_W'(PAGES_PER_BLOCK - 1)) begin
            pages_done <= pages_done + 1'b1;
            row_cur    <= row_cur + 1'b1;
            launch_q   <= 1'b1;
            ce_n_q     <= 1'b0;
            state      <= S_CMD;
          end else begin
            status_q <= ST_OK;
            done_q   <= 1'b1;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_index) && !rd_req));
  assert_read_needs_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !ce_n);
  assert_idle_ce_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || chk_valid) |-> ce_n);
  assert_chk_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_ready) |=> (chk_valid && $stable(chk_chunk) && $stable(chk_code)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy ##1 !done));
endmodule

// File: tb/nand_page_reader_bench.sv
module nand_page_reader_bench;
  localparam int NPG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0, block_mode = 1'b0;
  logic [15:0] base_row = '0;
  logic busy, done, ce_n, seq_valid, seq_is_cmd, rd_req, out_valid, chk_valid;
  logic [1:0] status;
  logic [7:0] seq_byte, out_data;
  logic [10:0] out_index;
  logic [1:0] chk_chunk;
  logic [23:0] chk_code;
  logic seq_ready = 1'b1, dev_ready = 1'b1, rd_ack = 1'b0, out_ready = 1'b1;
  logic chk_ready = 1'b1, res_valid = 1'b0, res_uncorr = 1'b0;
  logic [7:0] rd_data = 8'h00;

  nand_page_reader #(.PAGES_PER_BLOCK(NPG)) u_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .block_mode(block_mode), .base_row(base_row),
    .busy(busy), .done(done), .status(status), .ce_n(ce_n),
    .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_is_cmd(seq_is_cmd), .seq_byte(seq_byte),
    .dev_ready(dev_ready), .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_index(out_index),
    .chk_valid(chk_valid), .chk_ready(chk_ready), .chk_chunk(chk_chunk), .chk_code(chk_code),
    .res_valid(res_valid), .res_uncorr(res_uncorr));

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Device contents
  logic bad_en = 1'b0, fail_en = 1'b0, stall = 1'b0;
  logic [15:0] bad_row = '0, fail_row = '0;
  logic [1:0] fail_ck = '0;

  function automatic logic [7:0] pat(input logic [15:0] row, input int idx);
    logic [10:0] i;
    i = 11'(idx);
    return i[7:0] ^ (8'({5'd0, i[10:8]}) * 8'h1d) ^ row[7:0] ^ row[15:8];
  endfunction

  function automatic logic [7:0] spare(input logic [15:0] row, input int off);
    if (off == 0) return (bad_en && row == bad_row) ? 8'h00 : 8'hFF;
    return 8'(8'h40 + off * 5) + row[7:0];
  endfunction

  function automatic logic [23:0] code_of(input logic [15:0] row, input int c);
    return {spare(row, 3*c+3), spare(row, 3*c+2), spare(row, 3*c+1)};
  endfunction

  // Monitors
  logic [7:0] seq_log [64];
  logic       seq_cmd_log [64];
  int seq_n = 0, rd_pos = 0, rd_cnt = 0, out_cnt = 0, chk_cnt = 0;
  int data_err = 0, chk_err = 0, proto_err = 0, exp_idx = 0, exp_ck = 0;
  int busy_cnt = 0, pend = 0, negs = 0;
  bit rdy_ok = 1'b1, pend_fail = 1'b0, was_stall = 1'b0;
  logic [15:0] cur_row = '0;
  logic [7:0] row_lo = '0, held_data = '0;
  logic [10:0] held_idx = '0;

  initial begin
    forever begin
      @(negedge clk);
      negs++;
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) begin dev_ready = 1'b1; rdy_ok = 1'b1; end
      end
      res_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin res_valid = 1'b1; res_uncorr = pend_fail; end
      end
      out_ready = stall ? (negs % 3 != 0) : 1'b1;
      // protocol: R2, R9, R11
      if (rd_req && !rdy_ok) proto_err++;
      if (rd_req && ce_n) proto_err++;
      if (!busy && !ce_n) proto_err++;
      if (chk_valid && !ce_n) proto_err++;
      if (was_stall && (!out_valid || out_data != held_data || out_index != held_idx || rd_req)) proto_err++;
      was_stall = out_valid && !out_ready;
      held_data = out_data;
      held_idx  = out_index;
      rd_ack = rd_req;
      if (rd_req) begin
        rd_data = (rd_pos < 2048) ? pat(cur_row, rd_pos) : spare(cur_row, rd_pos - 2048);
        rd_pos++;
        rd_cnt++;
      end
      if (seq_valid && seq_ready) begin
        if (seq_n < 64) begin seq_log[seq_n] = seq_byte; seq_cmd_log[seq_n] = seq_is_cmd; end
        case (seq_n % 6)
          3: row_lo = seq_byte;
          4: cur_row = {seq_byte, row_lo};
          5: begin
            dev_ready = 1'b0; busy_cnt = 4; rdy_ok = 1'b0;
            rd_pos = (seq_log[(seq_n - 3) % 64] == 8'h08) ? 2048 : 0;
            exp_idx = 0; exp_ck = 0;
          end
          default: ;
        endcase
        seq_n++;
      end
      if (out_valid && out_ready) begin
        if (int'(out_index) != exp_idx || out_data != pat(cur_row, exp_idx)) data_err++;
        exp_idx++;
        out_cnt++;
      end
      if (chk_valid && chk_ready) begin
        if (pend > 0 || res_valid) chk_err++;
        if (int'(chk_chunk) != exp_ck || chk_code != code_of(cur_row, exp_ck)) chk_err++;
        pend_fail = fail_en && cur_row == fail_row && int'(chk_chunk) == int'(fail_ck);
        pend = 2;
        exp_ck++;
        chk_cnt++;
      end
    end
  end

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  // mode, bad, fail_en, fail_pg[1:0], fail_ck[1:0], stall, exp_st[1:0], exp_pages[2:0], exp_chks[3:0]
  localparam int NV = 7;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 3'd1, 4'd4},   // page ok
    {1'b0, 1'b0, 1'b1, 2'd0, 2'd2, 1'b0, 2'd2, 3'd1, 4'd3},   // page, chunk 2 fails
    {1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 2'd0, 3'd1, 4'd4},   // page with back-pressure
    {1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 3'd3, 4'd12},  // block good
    {1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 2'd1, 3'd0, 4'd0},   // block bad marker
    {1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b0, 2'd2, 3'd2, 4'd5},   // block, page 1 chunk 0 fails
    {1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 3'd1, 4'd4}    // page mode ignores marker
  };

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check(!busy && !done && ce_n && status == 2'd0, "R12 idle outputs", {busy, done, ce_n}, 3'b001);
    check(!seq_valid && !rd_req && !out_valid && !chk_valid, "R12 valids low",
          {seq_valid, rd_req, out_valid, chk_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [16:0] e;
      logic [15:0] base;
      int launches, seq_err, t, busy_gap;
      e = VEC[v];
      base = 16'h00a5 + 16'(v * 16'h0131);
      bad_en = e[15]; bad_row = base;
      fail_en = e[14]; fail_row = base + 16'(e[13:12]); fail_ck = e[11:10];
      stall = e[9];
      seq_n = 0; rd_cnt = 0; out_cnt = 0; chk_cnt = 0;
      data_err = 0; chk_err = 0; proto_err = 0; busy_gap = 0;
      block_mode = e[16]; base_row = base; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R10 busy after start", busy, 1);
      t = 0;
      while (!done && t < 60000) begin
        if (!busy) busy_gap++;
        @(negedge clk);
        t++;
      end
      check(!busy && done, "R10 done with busy low", {done, busy}, 2'b10);
      check(status == e[8:7], "R6 R7 R8 status", status, e[8:7]);
      check(out_cnt == 2048 * int'(e[6:4]), "R3 R8 streamed bytes", out_cnt, 2048 * int'(e[6:4]));
      check(data_err == 0, "R3 data and index order", data_err, 0);
      launches = int'(e[6:4]) + int'(e[16]);
      check(rd_cnt == 2112 * int'(e[6:4]) + 64 * int'(e[16]), "R3 R7 device reads",
            rd_cnt, 2112 * int'(e[6:4]) + 64 * int'(e[16]));
      check(chk_cnt == int'(e[3:0]), "R5 R6 check requests", chk_cnt, int'(e[3:0]));
      check(chk_err == 0, "R4 R5 check chunk and code", chk_err, 0);
      check(proto_err == 0 && busy_gap == 0, "R2 R9 R11 protocol", proto_err, 0);
      seq_err = 0;
      check(seq_n == 6 * launches, "R1 sequencer byte count", seq_n, 6 * launches);
      for (int k = 0; k < launches && k < 10; k++) begin
        logic [15:0] r;
        logic [7:0] ch;
        r  = base + 16'((e[16] && k > 0) ? k - 1 : k);
        ch = (e[16] && k == 0) ? 8'h08 : 8'h00;
        if (seq_log[6*k] != 8'h00 || !seq_cmd_log[6*k]) seq_err++;
        if (seq_log[6*k+1] != 8'h00 || seq_cmd_log[6*k+1]) seq_err++;
        if (seq_log[6*k+2] != ch || seq_cmd_log[6*k+2]) seq_err++;
        if (seq_log[6*k+3] != r[7:0] || seq_cmd_log[6*k+3]) seq_err++;
        if (seq_log[6*k+4] != r[15:8] || seq_cmd_log[6*k+4]) seq_err++;
        if (seq_log[6*k+5] != 8'h30 || !seq_cmd_log[6*k+5]) seq_err++;
      end
      check(seq_err == 0, "R1 R7 R8 command and address bytes", seq_err, 0);
      @(negedge clk);
      check(!done && status == e[8:7] && ce_n, "R10 R9 done pulse and status hold",
            {done, ce_n}, 2'b01);
      repeat (3) @(negedge clk);
    end

    // R12: reset in the middle of an operation
    block_mode = 1'b0; base_row = 16'h0042; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && ce_n && !rd_req && !seq_valid && status == 2'd0, "R12 reset mid-operation",
          {busy, ce_n, rd_req}, 3'b010);
    summary();
  end
endmodule